// File: doc/BRIEF.md
# Serial Flash Command Front-End with Write-Enable Gating

This block is the command-decoding front end of a serial NOR flash, seen from the SPI side in mode 0 (clock idle low, input sampled on the rising clock edge, output changed on the falling edge). The pins are oversampled by the fast system clock through two-stage synchronizers. A frame opens when chip select falls. The first eight bits on the data input form an opcode, sent most significant bit first.

Four opcodes are understood:

- **Write Enable (0x06)** sets a write-enable latch.
- **Write Disable (0x04)** clears the latch.
- **One-Time-Programmable Read (0x4B)** takes a 24-bit address and eight dummy clocks, then streams bytes from a small internal array on the data output for as long as chip select stays low.
- **One-Time-Programmable Program (0x42)** takes a 24-bit address and then data bytes, which are written into the array. It is accepted only when the latch is set.

A fast start-up option input is provided. When it is high, the first accepted Write Enable opens a busy window whose length in system clock cycles is a parameter. While that window is open, every frame is ignored.

Top module: `sflash_cmd_front`

## Requirements
- R1: After synchronous reset, `wel`, `busy`, `spi_dq1_oe` and `spi_dq1` are all 0, and every array byte reads 0xFF.
- R2: A frame holding exactly the 8 bits of opcode 0x06 sets `wel` when chip select rises.
- R3: Opcode 0x06 has no effect if the frame is ended after fewer than 8 bits, or if any bit follows the opcode.
- R4: A frame holding exactly the 8 bits of opcode 0x04 clears `wel` when chip select rises.
- R5: For opcode 0x4B, clocks 8 to 31 carry the address MSB first, and clocks 32 to 39 are dummy. From the falling edge after clock 39, `spi_dq1` carries array bytes MSB first, one bit per clock, valid at each rising edge.
- R6: `spi_dq1_oe` is 0 during the opcode, address and dummy clocks. It is 1 from the first data bit until chip select rises.
- R7: Read data continues byte after byte while chip select stays low. The address increments after each byte and wraps modulo `OTP_BYTES`. Address bits above log2(`OTP_BYTES`) are ignored.
- R8: With `wel` set, opcode 0x42 followed by a 24-bit address writes each completed data byte at the address, which increments and wraps as in R7. A final partial byte is discarded.
- R9: With `wel` clear, opcode 0x42 leaves the array unchanged.
- R10: A program frame that completed at least one data byte clears `wel` when chip select rises. A program frame aborted before its first data byte leaves `wel` set.
- R11: With `fast_por_en` high, the first accepted Write Enable raises `busy` for exactly `LAT_CYCLES` system clocks. Later Write Enables never raise it again.
- R12: While `busy` is high, every frame is ignored: Write Disable does not clear `wel`, and a read never enables `spi_dq1_oe`.
- R13: Any other opcode is ignored: `wel` is unchanged and `spi_dq1_oe` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock, mode 0 |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_dq0 | input | 1 | Serial data in |
| fast_por_en | input | 1 | Enables the busy window after the first Write Enable |
| spi_dq1 | output | 1 | Serial data out |
| spi_dq1_oe | output | 1 | Output enable for `spi_dq1` (0 = high impedance) |
| wel | output | 1 | Write-enable latch |
| busy | output | 1 | Start-up busy window active |

## Verification
Each pin crosses two synchronizer flops and one edge register. As a result, `wel` and `busy` settle three to four system clocks after chip select rises, and `spi_dq1` changes three to four clocks after a serial-clock fall.

The bench holds each serial-clock phase for six system clocks and captures read bits at the serial-clock rise, when the output has been stable for two or more clocks. It checks latch and busy state ten clocks after releasing chip select. It counts busy cycles on every system clock, so the length of the busy window is compared to the exact cycle count.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_OPC,
    PH_NOARG,
    PH_ADDR,
    PH_DUMMY,
    PH_RDATA,
    PH_WDATA,
    PH_DROP
  } phase_t;

  localparam logic [7:0] OP_WREN   = 8'h06;
  localparam logic [7:0] OP_WRDI   = 8'h04;
  localparam logic [7:0] OP_RD_OTP = 8'h4B;
  localparam logic [7:0] OP_PG_OTP = 8'h42;

  localparam int OPC_BITS   = 8;
  localparam int ADDR_BITS  = 24;
  localparam int DUMMY_BITS = 8;

endpackage

// File: rtl/sfc_pin_sync.sv
module sfc_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic cs_n,
  input  logic mosi,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_act,
  output logic cs_start,
  output logic cs_end,
  output logic mosi_s
);

  localparam int NP = 3;
  localparam logic [NP-1:0] RST_VAL = 3'b010;

  logic [NP-1:0] pin_in;
  logic [NP-1:0] pin_s;
  logic          sck_d;
  logic          cs_d;

  assign pin_in = {mosi, cs_n, sck};

  for (genvar g = 0; g < NP; g++) begin : g_pin
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{RST_VAL[g]}};
      else     chain <= {chain[STAGES-2:0], pin_in[g]};
    end
    assign pin_s[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d <= 1'b0;
      cs_d  <= 1'b1;
    end else begin
      sck_d <= pin_s[0];
      cs_d  <= pin_s[1];
    end
  end

  assign sck_rise = pin_s[0] & ~sck_d;
  assign sck_fall = ~pin_s[0] & sck_d;
  assign cs_act   = ~pin_s[1];
  assign cs_start = ~pin_s[1] & cs_d;
  assign cs_end   = pin_s[1] & ~cs_d;
  assign mosi_s   = pin_s[2];

endmodule

// File: rtl/sfc_otp_mem.sv
module sfc_otp_mem #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/sfc_ctrl.sv
module sfc_ctrl
  import sfc_pkg::*;
#(
  parameter int OTP_BYTES  = 64,
  parameter int LAT_CYCLES = 2000,
  localparam int AW = $clog2(OTP_BYTES),
  localparam int LW = $clog2(LAT_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sck_rise,
  input  logic          sck_fall,
  input  logic          cs_act,
  input  logic          cs_start,
  input  logic          cs_end,
  input  logic          mosi,
  input  logic          fast_por_en,
  input  logic [7:0]    mem_rdata,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [7:0]    mem_wdata,
  output logic [AW-1:0] mem_raddr,
  output logic          dq1_o,
  output logic          dq1_oe,
  output logic          wel,
  output logic          busy
);

  phase_t                 ph;
  logic [4:0]             bcnt;
  logic [6:0]             sh;
  logic [7:0]             opc;
  logic [ADDR_BITS-1:0]   addr;
  logic [7:0]             tx;
  logic                   prog_done;
  logic                   por_done;
  logic [LW-1:0]          lat_cnt;
  logic [7:0]             sh_next;

  assign sh_next   = {sh, mosi};
  assign mem_raddr = addr[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ph        <= PH_IDLE;
      bcnt      <= '0;
      sh        <= '0;
      opc       <= '0;
      addr      <= '0;
      tx        <= '0;
      prog_done <= 1'b0;
      por_done  <= 1'b0;
      lat_cnt   <= '0;
      busy      <= 1'b0;
      wel       <= 1'b0;
      dq1_o     <= 1'b0;
      dq1_oe    <= 1'b0;
      mem_we    <= 1'b0;
      mem_waddr <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      if (lat_cnt != '0) begin
        lat_cnt <= lat_cnt - 1'b1;
        if (lat_cnt == LW'(1)) busy <= 1'b0;
      end
      if (cs_start) begin
        ph        <= PH_OPC;
        bcnt      <= '0;
        prog_done <= 1'b0;
        dq1_oe    <= 1'b0;
      end else if (cs_end) begin
        if (ph == PH_NOARG) begin
          if (opc == OP_WREN) begin
            wel <= 1'b1;
            if (fast_por_en && !por_done) begin
              por_done <= 1'b1;
              lat_cnt  <= LW'(LAT_CYCLES);
              busy     <= 1'b1;
            end
          end else begin
            wel <= 1'b0;
          end
        end
        if (prog_done) wel <= 1'b0;
        ph     <= PH_IDLE;
        dq1_oe <= 1'b0;
        dq1_o  <= 1'b0;
      end else if (cs_act && sck_rise) begin
        sh   <= sh_next[6:0];
        bcnt <= bcnt + 1'b1;
        case (ph)
          PH_OPC: begin
            if (bcnt == 5'(OPC_BITS - 1)) begin
              bcnt <= '0;
              opc  <= sh_next;
              if (busy) ph <= PH_DROP;
              else begin
                case (sh_next)
                  OP_WREN, OP_WRDI: ph <= PH_NOARG;
                  OP_RD_OTP:        ph <= PH_ADDR;
                  OP_PG_OTP:        ph <= wel ? PH_ADDR : PH_DROP;
                  default:          ph <= PH_DROP;
                endcase
              end
            end
          end
          PH_NOARG: ph <= PH_DROP;
          PH_ADDR: begin
            addr <= {addr[ADDR_BITS-2:0], mosi};
            if (bcnt == 5'(ADDR_BITS - 1)) begin
              bcnt <= '0;
              ph   <= (opc == OP_PG_OTP) ? PH_WDATA : PH_DUMMY;
            end
          end
          PH_DUMMY: begin
            if (bcnt == 5'(DUMMY_BITS - 1)) begin
              bcnt <= '0;
              ph   <= PH_RDATA;
            end
          end
          PH_RDATA: begin
            if (bcnt == 5'd7) bcnt <= '0;
          end
          PH_WDATA: begin
            if (bcnt == 5'd7) begin
              bcnt      <= '0;
              mem_we    <= 1'b1;
              mem_wdata <= sh_next;
              mem_waddr <= addr[AW-1:0];
              addr      <= addr + 1'b1;
              prog_done <= 1'b1;
            end
          end
          default: ;
        endcase
      end else if (cs_act && sck_fall && ph == PH_RDATA) begin
        if (bcnt == '0) begin
          dq1_o  <= mem_rdata[7];
          tx     <= {mem_rdata[6:0], 1'b0};
          addr   <= addr + 1'b1;
          dq1_oe <= 1'b1;
        end else begin
          dq1_o <= tx[7];
          tx    <= {tx[6:0], 1'b0};
        end
      end
    end
  end

  a_r6_oe_only_in_data: assert property (@(posedge clk) disable iff (rst)
    dq1_oe |-> (ph == PH_RDATA));

  a_r9_write_needs_wel: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> wel);

  a_r12_no_write_while_busy: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !busy);

  a_r2_wel_sets_at_frame_end: assert property (@(posedge clk) disable iff (rst)
    $rose(wel) |-> $past(cs_end));

  a_r10_wel_clears_at_frame_end: assert property (@(posedge clk) disable iff (rst)
    $fell(wel) |-> $past(cs_end));

  a_r11_busy_from_wren: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(cs_end && ph == PH_NOARG && opc == OP_WREN && fast_por_en));

endmodule

// File: rtl/sflash_cmd_front.sv
module sflash_cmd_front #(
  parameter int OTP_BYTES   = 64,
  parameter int LAT_CYCLES  = 2000,
  parameter int SYNC_STAGES = 2,
  localparam int AW = $clog2(OTP_BYTES)
) (
  input  logic clk,
  input  logic rst,
  input  logic spi_sck,
  input  logic spi_cs_n,
  input  logic spi_dq0,
  input  logic fast_por_en,
  output logic spi_dq1,
  output logic spi_dq1_oe,
  output logic wel,
  output logic busy
);

  logic          sck_rise, sck_fall, cs_act, cs_start, cs_end, mosi_s;
  logic          mem_we;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic [7:0]    mem_wdata, mem_rdata;

  sfc_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .sck      (spi_sck),
    .cs_n     (spi_cs_n),
    .mosi     (spi_dq0),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .cs_act   (cs_act),
    .cs_start (cs_start),
    .cs_end   (cs_end),
    .mosi_s   (mosi_s)
  );

  sfc_ctrl #(.OTP_BYTES(OTP_BYTES), .LAT_CYCLES(LAT_CYCLES)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .sck_rise    (sck_rise),
    .sck_fall    (sck_fall),
    .cs_act      (cs_act),
    .cs_start    (cs_start),
    .cs_end      (cs_end),
    .mosi        (mosi_s),
    .fast_por_en (fast_por_en),
    .mem_rdata   (mem_rdata),
    .mem_we      (mem_we),
    .mem_waddr   (mem_waddr),
    .mem_wdata   (mem_wdata),
    .mem_raddr   (mem_raddr),
    .dq1_o       (spi_dq1),
    .dq1_oe      (spi_dq1_oe),
    .wel         (wel),
    .busy        (busy)
  );

  sfc_otp_mem #(.DEPTH(OTP_BYTES)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (mem_raddr),
    .rdata (mem_rdata)
  );

endmodule

// File: tb/test_sflash_cmd_front.sv
module test_sflash_cmd_front;

  localparam int OTP_BYTES = 64;
  localparam int LAT       = 2000;
  localparam int HALF      = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spi_sck = 1'b0;
  logic spi_cs_n = 1'b1;
  logic spi_dq0 = 1'b0;
  logic fast_por_en = 1'b0;
  logic spi_dq1, spi_dq1_oe, wel, busy;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [7:0] model [OTP_BYTES];
  logic [7:0] exp_q [$];
  logic [7:0] cap;
  int         nbits = 0;
  bit         oe_seen = 1'b0;
  int         busy_cycles = 0;

  always #4 clk = ~clk;

  sflash_cmd_front #(.OTP_BYTES(OTP_BYTES), .LAT_CYCLES(LAT)) i_sflash_cmd_front (
    .clk(clk), .rst(rst), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_dq0(spi_dq0),
    .fast_por_en(fast_por_en), .spi_dq1(spi_dq1), .spi_dq1_oe(spi_dq1_oe),
    .wel(wel), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: captures output bytes and compares them with the scoreboard queue
  always @(posedge spi_sck) begin
    if (spi_dq1_oe) begin
      oe_seen = 1'b1;
      cap = {cap[6:0], spi_dq1};
      nbits++;
      if (nbits == 8) begin
        nbits = 0;
        if (exp_q.size() == 0) check(1'b0, "R7 unexpected byte", int'(cap), 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(cap == e, "R5/R7 read byte", int'(cap), int'(e));
        end
      end
    end
  end
  always @(posedge spi_cs_n) nbits = 0;

  always @(posedge clk) if (!rst && busy) busy_cycles++;

  task automatic bit_out(input logic b);
    @(negedge clk) spi_dq0 = b;
    repeat (HALF) @(negedge clk);
    spi_sck = 1'b1;
    repeat (HALF) @(negedge clk);
    spi_sck = 1'b0;
  endtask

  task automatic bits_out(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) bit_out(v[i]);
  endtask

  task automatic cs_low();
    @(negedge clk) spi_cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_high();
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic short_cmd(input logic [7:0] op);
    cs_low(); bits_out(32'(op), 8); cs_high();
  endtask

  // driver: issues a read and pushes the expected bytes to the scoreboard
  task automatic otp_read(input logic [23:0] a, input int n, input bit expect_data);
    cs_low();
    bits_out(32'h4B, 8);
    bits_out(32'(a), 24);
    bits_out(0, 8);
    check(spi_dq1_oe == 1'b0, "R6 oe before data", int'(spi_dq1_oe), 0);
    if (expect_data)
      for (int k = 0; k < n; k++) exp_q.push_back(model[(int'(a) + k) % OTP_BYTES]);
    bits_out(0, 8 * n);
    cs_high();
    check(spi_dq1_oe == 1'b0, "R6 oe after frame", int'(spi_dq1_oe), 0);
  endtask

  initial begin
    for (int i = 0; i < OTP_BYTES; i++) model[i] = 8'hFF;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(wel == 0 && busy == 0 && spi_dq1_oe == 0 && spi_dq1 == 0, "R1 reset outputs",
          int'({wel, busy, spi_dq1_oe, spi_dq1}), 0);

    // R3: truncated and over-long write enable
    cs_low(); bits_out(32'h06 >> 3, 5); cs_high();
    check(wel == 0, "R3 short frame", int'(wel), 0);
    cs_low(); bits_out(32'h06, 8); bit_out(1'b0); cs_high();
    check(wel == 0, "R3 extra bit", int'(wel), 0);

    // R2 / R4
    short_cmd(8'h06);
    check(wel == 1, "R2 write enable", int'(wel), 1);
    short_cmd(8'h04);
    check(wel == 0, "R4 write disable", int'(wel), 0);

    // R9: program without the latch
    cs_low(); bits_out(32'h42, 8); bits_out(32'h000010, 24); bits_out(32'h00, 8); cs_high();
    otp_read(24'h000010, 1, 1'b1);
    check(wel == 0, "R9 latch still clear", int'(wel), 0);

    // R13: unknown opcode
    short_cmd(8'h06);
    oe_seen = 1'b0;
    cs_low(); bits_out(32'h9F, 8); bits_out(0, 16); cs_high();
    check(wel == 1 && !oe_seen, "R13 unknown opcode", int'({wel, oe_seen}), 2);

    // R8/R10: program across the wrap point
    cs_low(); bits_out(32'h42, 8); bits_out(32'h00003F, 24);
    bits_out(32'h5A, 8); bits_out(32'h11, 8); cs_high();
    model[63] = 8'h5A; model[0] = 8'h11;
    check(wel == 0, "R10 clear after program", int'(wel), 0);

    // R10: aborted during address keeps the latch
    short_cmd(8'h06);
    cs_low(); bits_out(32'h42, 8); bits_out(32'h0, 10); cs_high();
    check(wel == 1, "R10 abort keeps latch", int'(wel), 1);

    // R8: one full byte and a partial one
    cs_low(); bits_out(32'h42, 8); bits_out(32'h000005, 24);
    bits_out(32'h3C, 8); bits_out(32'h0, 4); cs_high();
    model[5] = 8'h3C;
    check(wel == 0, "R10 clear after partial", int'(wel), 0);

    otp_read(24'h000004, 3, 1'b1);        // R5, R8
    otp_read(24'hABCD3E, 4, 1'b1);        // R7 wrap and high bits ignored

    // R11 / R12: start-up busy window
    fast_por_en = 1'b1;
    busy_cycles = 0;
    short_cmd(8'h06);
    check(busy == 1 && wel == 1, "R11 busy after first enable", int'({busy, wel}), 3);
    short_cmd(8'h04);
    check(wel == 1, "R12 disable ignored while busy", int'(wel), 1);
    oe_seen = 1'b0;
    otp_read(24'h000000, 1, 1'b0);
    check(!oe_seen, "R12 read ignored while busy", int'(oe_seen), 0);
    repeat (LAT) @(negedge clk);
    check(busy == 0, "R11 busy ends", int'(busy), 0);
    check(busy_cycles == LAT, "R11 busy length", busy_cycles, LAT);
    short_cmd(8'h04);
    short_cmd(8'h06);
    check(busy == 0 && wel == 1, "R11 no second window", int'({busy, wel}), 1);

    check(exp_q.size() == 0, "R5 all bytes seen", exp_q.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule